// File: doc/BRIEF.md
# Enable-Gated Address Window Decoder

This block keeps a small bank of 64-bit configuration registers that describe three address windows: two memory-mapped windows, each set by a base and a mask register, and one register window of fixed length, set by a base register alone. A single enable register carries one switch per window. The host writes registers one at a time through an index and data port. Each register stores only the bits that its own keep mask allows. A combinational read port returns any stored register.

When a window's enable bit goes from 0 to 1, the block takes that window's base and length from the stored registers. Base and mask values are stored shifted left by 14 bits. The block then compares a lookup address against each enabled window and raises that window's hit output when the address falls inside it.

Writing a base or mask register while its window is live still stores the value, and it also raises a one-cycle warning. The live window keeps its old placement until the window is switched off and on again. A write to an index that holds no register raises a one-cycle error and changes nothing. At reset the bases load default values computed from chip and unit index inputs.

Top module: `bar_win_decoder`

## Requirements
- R1: Register indices 0 and 1 (memory window 0 and 1 base) and 2 and 3 (memory window 0 and 1 mask) keep only data bits 63:30 on a write; the lower bits read back as zero.
- R2: Index 4 (fixed window base) keeps only data bits 63:26 on a write.
- R3: Index 5 (enable) keeps only bits 63:59. Bit 63 switches memory window 0, bit 62 switches memory window 1 and bit 61 switches the fixed window.
- R4: After reset, with chip index c and unit index u: base 0 reads (0x3D00000000000 + 0x4000000000·c + 0x1000000000·u) << 14, base 1 reads (0x3FF8000000000 + 0x200000000·c + 0x80000000·u) << 14, the fixed base reads (0x3FFFE40000000 + 0x400000·c + 0x100000·u) << 14, mask 0 reads 0x3FFF000000000 << 14, mask 1 reads 0x3FFFF80000000 << 14, and enable reads 0.
- R5: An enabled memory window starts at its base register shifted right by 14. Its length is the inverted mask shifted right by 14, plus one. Its hit output is high exactly when start ≤ lookup address < start + length.
- R6: The fixed window starts at its base register shifted right by 14 and is always 0x1000 bytes long.
- R7: A window's start and length are captured in the cycle its enable bit rises. Later base or mask writes leave the live window in place until it is disabled and enabled again.
- R8: A write to indices 0 to 3 while memory window 0 or memory window 1 is enabled, or a write to index 4 while the fixed window is enabled, stores the value and raises the warning output for the next cycle only. No other write raises the warning.
- R9: A write to index 6 or 7 raises the error output for the next cycle only and changes no register.
- R10: A disabled window never hits. In an enable write that clears some bits and sets others, the cleared windows stop hitting in the same cycle that the new ones start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipId | input | 3 | Chip index used for the reset default bases |
| unitId | input | 2 | Unit index used for the reset default bases |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 3 | Register index of the write |
| wrData | input | 64 | Write data |
| rdIdx | input | 3 | Register index for the combinational read |
| rdData | output | 64 | Stored value at rdIdx (zero for unused indices) |
| lookAddr | input | 50 | Address to decode |
| hitMmio0 | output | 1 | lookAddr lies in memory window 0 |
| hitMmio1 | output | 1 | lookAddr lies in memory window 1 |
| hitFixed | output | 1 | lookAddr lies in the fixed window |
| warnPulse | output | 1 | A write reached a live window's base or mask |
| errPulse | output | 1 | A write used an unused index |

## Verification
Suppose the captured start or length of a window is wrong. The fault stays hidden until the window's enable bit rises. From the next cycle on it shows as a hit that is missing or extra at a window edge, so the bench probes both sides of every boundary. A wrong stored value shows on the read port in the cycle after the write. A wrong enable bit shows at once on the hit outputs, and also on the warning that a following base write produces. Because base writes to a live window have a delayed effect, the bench rewrites a live base, confirms that the old placement still holds, and then toggles the enable to make the new placement appear.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;
  localparam int REG_W    = 64;
  localparam int SHIFT    = 14;
  localparam int ADDR_W   = REG_W - SHIFT;
  localparam int SIZE_W   = ADDR_W + 1;
  localparam int NUM_REG  = 6;
  localparam int NUM_WIN  = 3;
  localparam int FIXED_LEN = 4096;

  // register indices
  localparam int IDX_BASE0 = 0;
  localparam int IDX_BASE1 = 1;
  localparam int IDX_MASK0 = 2;
  localparam int IDX_MASK1 = 3;
  localparam int IDX_FIXED = 4;
  localparam int IDX_EN    = 5;

  // enable bit of window w is bit (EN_TOP - w)
  localparam int EN_TOP = 63;

  localparam logic [REG_W-1:0] KEEP_MMIO  = 64'hFFFF_FFFF_C000_0000;
  localparam logic [REG_W-1:0] KEEP_FIXED = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [REG_W-1:0] KEEP_EN    = 64'hF800_0000_0000_0000;

  typedef struct packed {
    logic [NUM_REG-1:0] load;
    logic               badIdx;
  } winStrobe_t;

  function automatic logic [REG_W-1:0] keepOf(input int idx);
    if (idx == IDX_FIXED)   return KEEP_FIXED;
    else if (idx == IDX_EN) return KEEP_EN;
    else                    return KEEP_MMIO;
  endfunction
endpackage

// File: rtl/bar_win_ctrl.sv
module bar_win_ctrl
  import bar_win_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [NUM_WIN-1:0] enBits,
  output winStrobe_t         strobe,
  output logic               warnQ,
  output logic               errQ
);
  logic touchMmio;
  logic touchFixed;
  logic warnNext;

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (int'(wrIdx) < NUM_REG) strobe.load[wrIdx] = 1'b1;
      else                       strobe.badIdx = 1'b1;
    end
  end

  assign touchMmio  = wrEn && (int'(wrIdx) <= IDX_MASK1);
  assign touchFixed = wrEn && (int'(wrIdx) == IDX_FIXED);
  assign warnNext   = (touchMmio && |enBits[1:0]) || (touchFixed && enBits[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      warnQ <= warnNext;
      errQ  <= strobe.badIdx;
    end
  end
endmodule

// File: rtl/bar_win_regs.sv
module bar_win_regs
  import bar_win_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CHIP_W-1:0]               chipId,
  input  logic [UNIT_W-1:0]               unitId,
  input  winStrobe_t                      strobe,
  input  logic [REG_W-1:0]                wrData,
  input  logic [IDX_W-1:0]                rdIdx,
  output logic [REG_W-1:0]                rdData,
  output logic [NUM_WIN-1:0]              enBits,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  winBase,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]  winSize
);
  logic [NUM_REG-1:0][REG_W-1:0] regQ;
  logic [NUM_REG-1:0][REG_W-1:0] regDflt;
  logic [REG_W-1:0]              chipW;
  logic [REG_W-1:0]              unitW;
  logic [REG_W-1:0]              enNew;
  logic [NUM_WIN-1:0]            enRise;

  assign chipW = REG_W'(chipId);
  assign unitW = REG_W'(unitId);

  always_comb begin
    regDflt = '0;
    regDflt[IDX_BASE0] = (64'h3D00_0000_0000_0 + 64'h40_0000_0000 * chipW
                          + 64'h10_0000_0000 * unitW) << SHIFT;
    regDflt[IDX_BASE1] = (64'h3FF8_0000_0000_0 + 64'h2_0000_0000 * chipW
                          + 64'h8000_0000 * unitW) << SHIFT;
    regDflt[IDX_FIXED] = (64'h3FFF_E400_0000_0 + 64'h40_0000 * chipW
                          + 64'h10_0000 * unitW) << SHIFT;
    regDflt[IDX_MASK0] = 64'h3FFF_0000_0000_0 << SHIFT;
    regDflt[IDX_MASK1] = 64'h3FFF_F800_0000_0 << SHIFT;
  end

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               regQ[i] <= regDflt[i];
      else if (strobe.load[i]) regQ[i] <= wrData & keepOf(i);
    end
  end

  assign rdData = (int'(rdIdx) < NUM_REG) ? regQ[rdIdx] : '0;

  assign enNew = wrData & KEEP_EN;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] baseQ;
    logic [SIZE_W-1:0] sizeQ;
    logic [ADDR_W-1:0] baseNow;
    logic [SIZE_W-1:0] sizeNow;

    assign enBits[w] = regQ[IDX_EN][EN_TOP-w];
    assign enRise[w] = strobe.load[IDX_EN] && enNew[EN_TOP-w] && !enBits[w];

    if (w < 2) begin : g_mmio
      logic [REG_W-1:0] maskInv;
      assign maskInv = ~regQ[IDX_MASK0 + w];
      assign baseNow = ADDR_W'(regQ[IDX_BASE0 + w] >> SHIFT);
      assign sizeNow = SIZE_W'(maskInv >> SHIFT) + SIZE_W'(1);
    end else begin : g_fixed
      assign baseNow = ADDR_W'(regQ[IDX_FIXED] >> SHIFT);
      assign sizeNow = SIZE_W'(FIXED_LEN);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        sizeQ <= '0;
      end else if (enRise[w]) begin
        baseQ <= baseNow;
        sizeQ <= sizeNow;
      end
    end

    assign winBase[w] = baseQ;
    assign winSize[w] = sizeQ;
  end
endmodule

// File: rtl/bar_win_match.sv
module bar_win_match #(
  parameter int ADDR_W = 50,
  parameter int SIZE_W = ADDR_W + 1
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [SIZE_W-1:0] offset;

  assign offset = SIZE_W'(addr) - SIZE_W'(base);
  assign hit    = en && (addr >= base) && (offset < size);
endmodule

// File: rtl/bar_win_decoder.sv
module bar_win_decoder
  import bar_win_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHIP_W-1:0] chipId,
  input  logic [UNIT_W-1:0] unitId,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [REG_W-1:0]  rdData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hitMmio0,
  output logic              hitMmio1,
  output logic              hitFixed,
  output logic              warnPulse,
  output logic              errPulse
);
  winStrobe_t                     strobe;
  logic [NUM_WIN-1:0]             enBits;
  logic [NUM_WIN-1:0]             hitVec;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase;
  logic [NUM_WIN-1:0][SIZE_W-1:0] winSize;

  bar_win_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .enBits(enBits),
    .strobe(strobe), .warnQ(warnPulse), .errQ(errPulse)
  );

  bar_win_regs #(.IDX_W(IDX_W), .CHIP_W(CHIP_W), .UNIT_W(UNIT_W)) u_regs (
    .clk(clk), .rstN(rstN), .chipId(chipId), .unitId(unitId),
    .strobe(strobe), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .enBits(enBits), .winBase(winBase), .winSize(winSize)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    bar_win_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_match (
      .en(enBits[w]), .base(winBase[w]), .size(winSize[w]),
      .addr(lookAddr), .hit(hitVec[w])
    );
  end

  assign hitMmio0 = hitVec[0];
  assign hitMmio1 = hitVec[1];
  assign hitFixed = hitVec[2];
endmodule

// File: rtl/bar_win_checker.sv
module bar_win_checker
  import bar_win_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [IDX_W-1:0]   wrIdx,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [REG_W-1:0]   rdData,
  input logic [NUM_WIN-1:0] enBits,
  input logic [NUM_WIN-1:0] hitVec,
  input logic               warnPulse,
  input logic               errPulse
);
  AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (int'(wrIdx) >= NUM_REG) |=> errPulse);                      // R9
  AST_BAD_IDX_NO_EN_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (int'(wrIdx) >= NUM_REG) |=> $stable(enBits));               // R9
  AST_WARN_LIVE_MMIO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (int'(wrIdx) <= IDX_MASK1) && (|enBits[1:0]) |=> warnPulse); // R8
  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !warnPulse && !errPulse);                                  // R8
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec & ~enBits) == '0);                                           // R10
  AST_MMIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdIdx) <= IDX_MASK1) |-> (rdData[29:0] == '0));               // R1
endmodule

bind bar_win_decoder bar_win_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .rdIdx(rdIdx),
  .rdData(rdData), .enBits(enBits), .hitVec(hitVec),
  .warnPulse(warnPulse), .errPulse(errPulse)
);

// File: tb/tb_bar_win_decoder.sv
module tb_bar_win_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  chipId = 3'd1;
  logic [1:0]  unitId = 2'd2;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic [49:0] lookAddr = '0;
  logic        hitMmio0, hitMmio1, hitFixed, warnPulse, errPulse;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bar_win_decoder dut (
    .clk(clk), .rstN(rstN), .chipId(chipId), .unitId(unitId),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx),
    .rdData(rdData), .lookAddr(lookAddr), .hitMmio0(hitMmio0),
    .hitMmio1(hitMmio1), .hitFixed(hitFixed), .warnPulse(warnPulse),
    .errPulse(errPulse)
  );

  // {address, expected {fixed, mmio1, mmio0}}
  localparam logic [52:0] VEC [11] = '{
    {50'h0_3FFF_FFFF, 3'b000}, {50'h0_4000_0000, 3'b001},
    {50'h0_4000_FFFF, 3'b001}, {50'h0_4001_0000, 3'b000},
    {50'h0_8000_0000, 3'b010}, {50'h0_8001_FFFF, 3'b010},
    {50'h0_8002_0000, 3'b000}, {50'h0_C000_0000, 3'b100},
    {50'h0_C000_0FFF, 3'b100}, {50'h0_C000_1000, 3'b000},
    {50'h0_7FFF_FFFF, 3'b000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [63:0] val);
    rdIdx = idx;
    #1;
    val = rdData;
  endtask

  task automatic look(input string tag, input logic [49:0] a, input logic [2:0] exp);
    lookAddr = a;
    #1;
    check(tag, {61'd0, hitFixed, hitMmio1, hitMmio0}, {61'd0, exp});
  endtask

  initial begin
    logic [63:0] v;
    logic [63:0] c, u;
    c = 64'd1; u = 64'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 reset defaults
    rd(3'd0, v); check("R4 base0", v, (64'h3D00000000000 + 64'h4000000000*c + 64'h1000000000*u) << 14);
    rd(3'd1, v); check("R4 base1", v, (64'h3FF8000000000 + 64'h200000000*c + 64'h80000000*u) << 14);
    rd(3'd4, v); check("R4 fixed", v, (64'h3FFFE40000000 + 64'h400000*c + 64'h100000*u) << 14);
    rd(3'd2, v); check("R4 mask0", v, 64'h3FFF000000000 << 14);
    rd(3'd3, v); check("R4 mask1", v, 64'h3FFFF80000000 << 14);
    rd(3'd5, v); check("R4 enable", v, 64'd0);
    look("R10 disabled", 50'h3D06000000000, 3'b000);

    // R1 / R2 keep masks, no warning while disabled
    wr(3'd0, '1); check("R8 no warn disabled", {63'd0, warnPulse}, 64'd0);
    rd(3'd0, v); check("R1 base keep", v, 64'hFFFF_FFFF_C000_0000);
    wr(3'd3, 64'h0123_4567_89AB_CDEF);
    rd(3'd3, v); check("R1 mask keep", v, 64'h0123_4567_8000_0000);
    wr(3'd4, '1);
    rd(3'd4, v); check("R2 fixed keep", v, 64'hFFFF_FFFF_FC00_0000);

    // configure windows
    wr(3'd0, 64'h0000_1000_0000_0000);
    wr(3'd2, 64'hFFFF_FFFF_C000_0000);
    wr(3'd1, 64'h0000_2000_0000_0000);
    wr(3'd3, 64'hFFFF_FFFF_8000_0000);
    wr(3'd4, 64'h0000_3000_0000_0000);
    wr(3'd5, 64'hE000_0000_0000_0000);

    // R5 / R6 vector table
    for (int i = 0; i < 11; i++)
      look("R5 R6 window table", VEC[i][52:3], VEC[i][2:0]);

    // R8 warning on live base, value stored; R7 window stays put
    wr(3'd0, 64'h0000_5000_0000_0000);
    check("R8 warn live base", {63'd0, warnPulse}, 64'd1);
    rd(3'd0, v); check("R8 stored anyway", v, 64'h0000_5000_0000_0000);
    look("R7 old placement", 50'h0_4000_0000, 3'b001);
    look("R7 new not yet", 50'h1_4000_0000, 3'b000);
    @(negedge clk);
    check("R8 warn one cycle", {63'd0, warnPulse}, 64'd0);

    // R7 re-enable picks up new base
    wr(3'd5, 64'h6000_0000_0000_0000);
    look("R10 mmio0 off", 50'h0_4000_0000, 3'b000);
    wr(3'd5, 64'hE000_0000_0000_0000);
    look("R7 new placement", 50'h1_4000_0000, 3'b001);
    look("R7 old gone", 50'h0_4000_0000, 3'b000);

    // R10 clear and set in one write
    wr(3'd5, 64'h2000_0000_0000_0000);
    look("R10 mmio1 cleared", 50'h0_8000_0000, 3'b000);
    look("R10 fixed kept", 50'h0_C000_0000, 3'b100);
    wr(3'd5, 64'hC000_0000_0000_0000);
    look("R10 fixed cleared", 50'h0_C000_0000, 3'b000);
    look("R10 mmio1 set", 50'h0_8000_0000, 3'b010);
    look("R10 mmio0 set", 50'h1_4000_0000, 3'b001);

    // R8 fixed-only live: mmio write no warn, fixed write warns
    wr(3'd5, 64'h2000_0000_0000_0000);
    wr(3'd3, 64'hFFFF_FFFF_8000_0000);
    check("R8 no warn mmio off", {63'd0, warnPulse}, 64'd0);
    wr(3'd4, 64'h0000_3000_0000_0000);
    check("R8 warn live fixed", {63'd0, warnPulse}, 64'd1);

    // R3 enable keep
    wr(3'd5, '1);
    rd(3'd5, v); check("R3 enable keep", v, 64'hF800_0000_0000_0000);

    // R9 unused index
    wr(3'd6, 64'd0);
    check("R9 err idx6", {63'd0, errPulse}, 64'd1);
    check("R9 no warn", {63'd0, warnPulse}, 64'd0);
    rd(3'd5, v); check("R9 enable unchanged", v, 64'hF800_0000_0000_0000);
    look("R9 hit unchanged", 50'h0_C000_0000, 3'b100);
    wr(3'd7, '1);
    check("R9 err idx7", {63'd0, errPulse}, 64'd1);
    rd(3'd7, v); check("R9 read unused", v, 64'd0);
    rd(3'd0, v); check("R9 base0 unchanged", v, 64'h0000_5000_0000_0000);
    @(negedge clk);
    check("R9 err one cycle", {63'd0, errPulse}, 64'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule